// File: doc/BRIEF.md
# Coherency Unit Register Block

This block is the software-visible register window of a multicore cache-coherency unit. A simple request bus reaches it. Each request carries a strobe, a read/write flag, an 8-bit byte offset, a byte-count size code and 32-bit write data. The block keeps three things. The first is a one-bit enable for the coherency unit. The second is a read-only configuration word built from the CPU-count parameter. The third is a 32-bit power-status word holding one byte for each CPU.

The power-status word can be reached at each of its four byte offsets, with accesses of one, two or four bytes. A write replaces only the bytes that the access covers. Any part of the access that would fall above bit 31 is discarded. The offsets for the invalidate command, the address filters, the access control registers and every unmapped offset all read as zero and ignore writes. Read data comes back through a register one clock after the read strobe.

Top module: `coh_regblk`

## Requirements
- R1: A valid-size write to offset 0x00 stores bit 0 of the write data in the enable bit. A read of offset 0x00 returns that bit in bit 0, with zeros in bits 31:1.
- R2: A read of offset 0x04 returns a mask of NUM_CPU ones in bits starting at bit 4, and NUM_CPU-1 in bits 1:0. With NUM_CPU=3 the value is 0x00000072. NUM_CPU must lie in 1..4, and writes to 0x04 change nothing.
- R3: A read of offset 0x08+k, for k from 0 to 3, returns the power-status word shifted right by 8*k bits, with zeros filled in from the top.
- R4: A valid-size write to offset 0x08+k replaces the status bytes k up to min(3, k+bytes-1) with the write-data bytes 0, 1 and so on, in that order. All other status bytes keep their values.
- R5: The size code req_size gives the access width in bytes. Only the values 1, 2 and 4 are valid. A write with any other size code changes no state.
- R6: Offset 0x0C and every offset from 0x10 to 0xFF read as zero. A write to any of these offsets changes neither the enable bit nor the status word.
- R7: A read strobe makes rsp_valid high for exactly the next cycle, with the read data on rsp_rdata. In cycles with no read, rsp_valid is low and rsp_rdata holds its last value.
- R8: Synchronous active-low reset clears the enable bit, the status word, rsp_valid and rsp_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle for each access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the 256-byte window |
| req_size | input | 3 | Access width in bytes (1, 2 or 4 are valid) |
| req_wdata | input | 32 | Write data, right-aligned to the addressed byte |
| rsp_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rsp_rdata | output | 32 | Registered read data |

## Verification
The bench goes after the status merge at offsets that do not fall on a word boundary. Two examples are a halfword written at offset 0x0B and a full word written at offset 0x09. A design that wraps the shifted data instead of truncating it would corrupt the low status bytes there. A design that clears bytes the access does not cover would lose neighbouring CPU states.

Writes with illegal size codes go to both the enable bit and the status word. A design that decodes the size loosely would change state on them. Reads of the configuration word with a non-default CPU count show whether the mask and the count field are misplaced. Writes aimed at zero-reading offsets show whether a decoder aliases them onto live registers.

// File: rtl/coh_regblk_pkg.sv
// Package: shared offsets and size helpers for the coherency register block.
// Assumes byte offsets of 8 bits and a size code that counts bytes.
package coh_regblk_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned SIZE_W  = 3;
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned LANE_IW = $clog2(LANES);

    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h08;

    // Number of bytes an access covers (0 means the size code is illegal)
    function automatic logic [SIZE_W:0] size_bytes(input logic [SIZE_W-1:0] sz);
        case (sz)
            3'd1:    return 4'd1;
            3'd2:    return 4'd2;
            3'd4:    return 4'd4;
            default: return 4'd0;
        endcase
    endfunction

    // True when the size code is legal
    function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
        return size_bytes(sz) != '0;
    endfunction

endpackage

// File: rtl/coh_lane_enable.sv
// Module: per-byte-lane write enables for the status word.
// Purpose: works out which status bytes an access at lane offset `base`
// of the given size covers. Lanes above the top of the word are dropped.
// Assumes: `en` already includes strobe, write and address hit.
module coh_lane_enable
    import coh_regblk_pkg::*;
#(
    parameter int unsigned NLANES = LANES
) (
    input  logic                        en,
    input  logic [SIZE_W-1:0]           size,
    input  logic [$clog2(NLANES)-1:0]   base,
    output logic [NLANES-1:0]           lane_we
);

    localparam int unsigned CNT_W = $clog2(NLANES) + SIZE_W + 1;

    logic [CNT_W-1:0] first_lane;
    logic [CNT_W-1:0] end_lane;

    // Range of covered lanes: [first_lane, end_lane)
    always_comb begin
        first_lane = CNT_W'(base);
        end_lane   = CNT_W'(base) + CNT_W'(size_bytes(size));
    end

    for (genvar j = 0; j < NLANES; j++) begin : g_lane
        // One lane is enabled when it lies inside the covered range
        always_comb begin
            lane_we[j] = en && (CNT_W'(j) >= first_lane) && (CNT_W'(j) < end_lane);
        end
    end

endmodule

// File: rtl/coh_pwr_status.sv
// Module: power-status word with byte-lane merge writes.
// Purpose: each enabled lane j takes write-data byte (j - base). Lanes that
// are not enabled keep their value. Synchronous active-low reset to zero.
// Assumes: lane_we only enables lanes j >= base.
module coh_pwr_status
    import coh_regblk_pkg::*;
#(
    parameter int unsigned NLANES = LANES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NLANES-1:0]           lane_we,
    input  logic [$clog2(NLANES)-1:0]   base,
    input  logic [8*NLANES-1:0]         wdata,
    output logic [8*NLANES-1:0]         status
);

    localparam int unsigned IW = $clog2(NLANES);

    for (genvar j = 0; j < NLANES; j++) begin : g_byte
        logic [IW-1:0] src_idx;
        logic [7:0]    src_byte;

        // Select the write-data byte that lands on this lane
        always_comb begin
            src_idx  = IW'(j) - base;
            src_byte = wdata[8*src_idx +: 8];
        end

        // Hold or replace this status byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                status[8*j +: 8] <= 8'h00;
            else if (lane_we[j])
                status[8*j +: 8] <= src_byte;
        end
    end

endmodule

// File: rtl/coh_read_mux.sv
// Module: read-data selection for the coherency register window.
// Purpose: decodes the byte offset into the value that a read returns.
// Offsets that are not mapped return zero.
// Assumes: NUM_CPU in 1..4.
module coh_read_mux
    import coh_regblk_pkg::*;
#(
    parameter int unsigned NUM_CPU = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ctrl,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] CPU_MASK = DATA_W'((1 << NUM_CPU) - 1);
    localparam logic [DATA_W-1:0] CFG_WORD = (CPU_MASK << 4) | DATA_W'(NUM_CPU - 1);

    // Offset decode
    always_comb begin
        rdata = '0;
        if (addr == OFF_CTRL)
            rdata = {{(DATA_W-1){1'b0}}, ctrl};
        else if (addr == OFF_CFG)
            rdata = CFG_WORD;
        else if (addr[ADDR_W-1:LANE_IW] == OFF_STAT[ADDR_W-1:LANE_IW])
            rdata = status >> {addr[LANE_IW-1:0], 3'b000};
    end

endmodule

// File: rtl/coh_regblk.sv
// Module: register window of a multicore coherency unit.
// Purpose: holds the enable bit and the power-status word and serves
// registered reads one cycle after the strobe.
// Assumes: one request per strobe cycle and a synchronous active-low reset.
module coh_regblk
    import coh_regblk_pkg::*;
#(
    parameter int unsigned NUM_CPU = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);

    if (NUM_CPU < 1 || NUM_CPU > 4) begin : g_bad_cpu
        $error("coh_regblk: NUM_CPU must be 1..4");
    end

    logic              wr_fire;
    logic              rd_fire;
    logic              stat_hit;
    logic [LANES-1:0]  lane_we;
    logic              ctrl_q;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] rd_next;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    // Request qualification
    always_comb begin
        wr_fire  = req_valid && req_write && size_legal(req_size);
        rd_fire  = req_valid && !req_write;
        stat_hit = req_addr[ADDR_W-1:LANE_IW] == OFF_STAT[ADDR_W-1:LANE_IW];
    end

    coh_lane_enable #(.NLANES(LANES)) u_lanes (
        .en      (wr_fire && stat_hit),
        .size    (req_size),
        .base    (req_addr[LANE_IW-1:0]),
        .lane_we (lane_we)
    );

    coh_pwr_status #(.NLANES(LANES)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .base    (req_addr[LANE_IW-1:0]),
        .wdata   (req_wdata),
        .status  (status_q)
    );

    coh_read_mux #(.NUM_CPU(NUM_CPU)) u_rmux (
        .addr   (req_addr),
        .ctrl   (ctrl_q),
        .status (status_q),
        .rdata  (rd_next)
    );

    // Enable bit: keeps bit 0 of a legal write to the control offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 1'b0;
        else if (wr_fire && req_addr == OFF_CTRL)
            ctrl_q <= req_wdata[0];
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= rd_fire;
            if (rd_fire)
                rsp_rdata_q <= rd_next;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/coh_regblk_chk.sv
// Module: assertion checker bound to coh_regblk.
// Purpose: checks enable, status, size and response timing over time.
module coh_regblk_chk
    import coh_regblk_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_addr,
    input logic [2:0]  req_size,
    input logic [31:0] req_wdata,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        ctrl_q,
    input logic [31:0] status_q
);

    AST_CTRL_TAKES_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 8'h00 && size_legal(req_size))
        |=> ctrl_q == $past(req_wdata[0])); // R1

    AST_STATUS_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && req_addr[7:2] == 6'd2) |=> $stable(status_q)); // R4

    AST_BAD_SIZE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !size_legal(req_size))
        |=> ($stable(status_q) && $stable(ctrl_q))); // R5

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr >= 8'h0C) |=> rsp_rdata == 32'h0); // R6

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R7

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> (!rsp_valid && $stable(rsp_rdata))); // R7

endmodule

bind coh_regblk coh_regblk_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ctrl_q    (ctrl_q),
    .status_q  (status_q)
);

// File: tb/coh_regblk_tb.sv
`timescale 1ns/1ps
module coh_regblk_tb;

    localparam int NCPU = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural reference state
    bit          m_ctrl;
    logic [31:0] m_status;
    bit          m_rvalid;
    logic [31:0] m_rdata;

    always #10 clk = ~clk;

    coh_regblk #(.NUM_CPU(NCPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int unsigned off;
        off = a;
        if (off == 0) return {31'b0, m_ctrl};
        if (off == 4) return 32'((((1 << NCPU) - 1) * 16) + (NCPU - 1));
        if (off >= 8 && off <= 11) return m_status >> ((off - 8) * 8);
        return 32'h0;
    endfunction

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_status = 0; m_rvalid = 0; m_rdata = 0;
        end else begin
            m_rvalid = req_valid && !req_write;
            if (req_valid && !req_write) m_rdata = model_read(req_addr);
            if (req_valid && req_write &&
                (req_size == 1 || req_size == 2 || req_size == 4)) begin
                logic [63:0] msk;
                int unsigned sh;
                msk = (req_size == 1) ? 64'hFF : (req_size == 2) ? 64'hFFFF : 64'hFFFF_FFFF;
                if (req_addr == 8'h00) m_ctrl = req_wdata[0];
                if (req_addr >= 8'h08 && req_addr <= 8'h0B) begin
                    sh = (int'(req_addr) - 8) * 8;
                    m_status = 32'(({32'h0, m_status} & ~(msk << sh)) |
                                   (({32'h0, req_wdata} & msk) << sh));
                end
            end
        end
    end

    // Cycle-by-cycle comparison against the model (R7, R8)
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rsp_valid !== m_rvalid || rsp_rdata !== m_rdata) begin
                errors++;
                $display("FAIL R7 cycle compare: actual valid=%0b data=%08h expected valid=%0b data=%08h",
                         rsp_valid, rsp_rdata, m_rvalid, m_rdata);
            end
        end
    end

    task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_size = 3'd4;
        @(negedge clk);
        req_valid = 0;
        d = rsp_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        expect_eq(req, d, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state visible at the ports
        expect_eq("R8 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        expect_eq("R8 rsp_rdata after reset", rsp_rdata, 32'h0);
        rst_n = 1;
        rd_chk("R8 enable cleared", 8'h00, 32'h0);
        rd_chk("R8 status cleared", 8'h08, 32'h0);

        // R1: only bit 0 kept
        wr(8'h00, 3'd4, 32'hFFFF_FFFF);
        rd_chk("R1 enable set", 8'h00, 32'h1);
        wr(8'h00, 3'd1, 32'h0000_0002);
        rd_chk("R1 enable cleared by bit0=0", 8'h00, 32'h0);

        // R2: configuration word, write ignored
        rd_chk("R2 config", 8'h04, 32'h0000_0072);
        wr(8'h04, 3'd4, 32'hFFFF_FFFF);
        rd_chk("R2 config after write", 8'h04, 32'h0000_0072);

        // R3: shifted views of the status word
        wr(8'h08, 3'd4, 32'h1122_3344);
        rd_chk("R3 read 0x08", 8'h08, 32'h1122_3344);
        rd_chk("R3 read 0x09", 8'h09, 32'h0011_2233);
        rd_chk("R3 read 0x0A", 8'h0A, 32'h0000_1122);
        rd_chk("R3 read 0x0B", 8'h0B, 32'h0000_0011);

        // R4: merge writes at byte offsets
        wr(8'h09, 3'd1, 32'hFFFF_FFAB);
        rd_chk("R4 byte at 0x09", 8'h08, 32'h1122_AB44);
        wr(8'h0A, 3'd2, 32'h0000_BEEF);
        rd_chk("R4 half at 0x0A", 8'h08, 32'hBEEF_AB44);
        wr(8'h0B, 3'd2, 32'h0000_5566);
        rd_chk("R4 half at 0x0B truncated", 8'h08, 32'h66EF_AB44);
        wr(8'h09, 3'd4, 32'h1234_5678);
        rd_chk("R4 word at 0x09 truncated", 8'h08, 32'h3456_7844);

        // R5: illegal size codes leave state alone
        wr(8'h08, 3'd3, 32'h0);
        wr(8'h08, 3'd0, 32'h0);
        rd_chk("R5 status after bad sizes", 8'h08, 32'h3456_7844);
        wr(8'h00, 3'd4, 32'h1);
        wr(8'h00, 3'd7, 32'h0);
        rd_chk("R5 enable after bad size", 8'h00, 32'h1);

        // R6: zero-reading offsets ignore writes
        wr(8'h0C, 3'd4, 32'hFFFF_FFFF);
        wr(8'h40, 3'd4, 32'hFFFF_FFFF);
        wr(8'h44, 3'd4, 32'hFFFF_FFFF);
        wr(8'h50, 3'd4, 32'hFFFF_FFFF);
        wr(8'hFC, 3'd1, 32'h0000_0000);
        rd_chk("R6 read 0x0C", 8'h0C, 32'h0);
        rd_chk("R6 read 0x40", 8'h40, 32'h0);
        rd_chk("R6 read 0x54", 8'h54, 32'h0);
        rd_chk("R6 status kept", 8'h08, 32'h3456_7844);
        rd_chk("R6 enable kept", 8'h00, 32'h1);

        // R7: data holds with no read
        repeat (3) @(negedge clk);
        expect_eq("R7 rdata held", rsp_rdata, 32'h1);
        expect_eq("R7 valid low when idle", {31'b0, rsp_valid}, 32'h0);

        // Random traffic compared against the model each cycle
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            req_valid = ($urandom_range(0, 3) != 0);
            req_write = $urandom_range(0, 1);
            case ($urandom_range(0, 3))
                0: req_addr = 8'(8 + $urandom_range(0, 3));
                1: req_addr = 8'(4 * $urandom_range(0, 3));
                default: req_addr = 8'($urandom);
            endcase
            req_size  = 3'($urandom);
            req_wdata = $urandom;
        end
        @(negedge clk);
        req_valid = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule